// File: doc/BRIEF.md
# Timer-Counter PWM Channel

This block is one pulse-width channel built around a 16-bit up-counter. The counter advances on clock cycles where an external tick enable is high and the channel's run bit is set. Each period starts at a programmable initial level. The output flips to the opposite level once the count reaches the duty compare value. It stays there until the count reaches the period compare value, and on the next tick the counter reloads to zero. If the duty value is above the period value, the output keeps its initial level for the whole period.

Software sees four registers through a simple write port and a combinational read port:

| Address | Register |
|---|---|
| 0 | Control |
| 1 | Counter |
| 2 | Duty compare |
| 3 | Period compare |

The duty and period values the compare logic uses are shadow copies. The shadows reload while the counter is stopped, and at each wrap, so a value written mid-period cannot produce a partial period.

Clearing the PWM-enable bit takes the output out of compare control. A small state machine handles this with three states: OFF (output at the initial level, not driven by the compare logic), ON, and DRAIN. DRAIN is used for graceful shutdown and finishes the current period first. Its transitions are:

- OFF to ON when PWM-enable is set.
- ON to OFF when PWM-enable is clear and any of these holds: abrupt mode is selected, the counter is stopped, or a wrap happens in that cycle.
- ON to DRAIN when PWM-enable is clear and none of those three conditions holds.
- DRAIN to ON when PWM-enable is set again.
- DRAIN to OFF on a wrap, on abrupt mode, or when the counter is stopped.

Top module: `pwm_timer_channel`

## Requirements
- R1: After reset, every register reads zero, `pwm_oe` is low and `pwm_out` is low.
- R2: The counter (address 1) increments only on cycles where `tick_en` is high and control bit 0 (run) is set. Otherwise it holds its value, and clearing run does not reset it.
- R3: On a counting cycle where the counter equals the active period value, the counter becomes zero after that edge.
- R4: While the output is under compare control, `pwm_out` equals control bit 2 (initial level) while the count is below the active duty value. It equals the inverse of that bit from the duty match until the wrap.
- R5: When the active duty value is greater than the active period value, `pwm_out` stays at the initial level for the whole period.
- R6: A write to address 1 loads the counter directly. It takes priority over counting in the same cycle.
- R7: Values written to duty (address 2) and period (address 3) reach the compare logic only while run is clear, or at a wrap. Reading these addresses returns the written values.
- R8: Control bit 1 (PWM-enable) puts the output under compare control, shown by `pwm_oe` high, starting one cycle after the control register holds it. When not under compare control, `pwm_out` sits at the initial level.
- R9: With control bit 3 (abrupt) set, clearing PWM-enable drops `pwm_oe` and returns `pwm_out` to the initial level one cycle after the control register changes. With bit 3 clear, the current period runs to its wrap first.
- R10: Clearing run while PWM-enable is clear ends a pending graceful shutdown one cycle later, with `pwm_out` at the initial level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Prescaled count enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 control, 1 counter, 2 duty, 3 period) |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Read address, same map as writes |
| rd_data | output | 16 | Combinational read data |
| pwm_out | output | 1 | PWM output level |
| pwm_oe | output | 1 | High while the compare logic drives the output |

## Verification
The hardest condition to reach is a graceful shutdown that is still draining when a wrap, or a stop of the counter, arrives. Reaching it means clearing PWM-enable in the middle of the opposite-level phase, then letting the period run out, or stopping the counter before it does. Directed sequences wait on the counter read-back until a chosen count, then issue the control write with ticks running. A held-off tick is used in the same way to freeze the count while a new duty value is written, to show that the shadow copy holds. Random periods, duties, levels and tick patterns are checked against a bench model of counter and level.

// File: rtl/pwm_chan_pkg.sv
package pwm_chan_pkg;
    localparam logic [1:0] ADDR_CTRL   = 2'd0;
    localparam logic [1:0] ADDR_COUNT  = 2'd1;
    localparam logic [1:0] ADDR_DUTY   = 2'd2;
    localparam logic [1:0] ADDR_PERIOD = 2'd3;

    localparam int CTL_W      = 4;
    localparam int CTL_RUN    = 0;
    localparam int CTL_PWM    = 1;
    localparam int CTL_INIT   = 2;
    localparam int CTL_ABRUPT = 3;

    typedef enum logic [1:0] {
        PS_OFF   = 2'd0,
        PS_ON    = 2'd1,
        PS_DRAIN = 2'd2
    } pwm_state_e;
endpackage

// File: rtl/pwm_counter.sv
module pwm_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             run,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [CNT_W-1:0] duty_prog,
    input  logic [CNT_W-1:0] per_prog,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] duty_act,
    output logic [CNT_W-1:0] per_act,
    output logic             wrap
);
    logic step;
    logic load;

    assign step = tick_en & run;
    assign wrap = step & (count == per_act);
    assign load = ~run | wrap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (cnt_wr) begin
            count <= wr_data;
        end else if (step) begin
            count <= wrap ? '0 : count + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            duty_act <= '0;
            per_act  <= '0;
        end else if (load) begin
            duty_act <= duty_prog;
            per_act  <= per_prog;
        end
    end

    assert_wrap_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && !cnt_wr) |=> (count == '0));
    assert_hold_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!(tick_en && run) && !cnt_wr) |=> $stable(count));
    assert_direct_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> (count == $past(wr_data)));
    assert_shadow_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !wrap) |=> ($stable(duty_act) && $stable(per_act)));
endmodule

// File: rtl/pwm_compare.sv
module pwm_compare #(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] duty_act,
    input  logic [CNT_W-1:0] per_act,
    output logic             opposite
);
    logic duty_reached;
    logic duty_valid;

    assign duty_reached = (count >= duty_act);
    assign duty_valid   = (duty_act <= per_act);
    assign opposite     = duty_reached & duty_valid;
endmodule

// File: rtl/pwm_out_fsm.sv
module pwm_out_fsm
    import pwm_chan_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pwm_en,
    input  logic abrupt,
    input  logic run,
    input  logic wrap,
    input  logic init_high,
    input  logic opposite,
    output logic pwm_out,
    output logic pwm_oe
);
    pwm_state_e state;
    pwm_state_e state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            PS_OFF: begin
                if (pwm_en) state_nx = PS_ON;
            end
            PS_ON: begin
                if (!pwm_en) begin
                    if (abrupt || !run || wrap) state_nx = PS_OFF;
                    else                        state_nx = PS_DRAIN;
                end
            end
            PS_DRAIN: begin
                if (pwm_en)                       state_nx = PS_ON;
                else if (abrupt || !run || wrap)  state_nx = PS_OFF;
            end
            default: state_nx = PS_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= PS_OFF;
        else        state <= state_nx;
    end

    always_comb begin
        pwm_oe  = 1'b0;
        pwm_out = init_high;
        unique case (state)
            PS_OFF: begin
                pwm_oe  = 1'b0;
                pwm_out = init_high;
            end
            PS_ON, PS_DRAIN: begin
                pwm_oe  = 1'b1;
                pwm_out = init_high ^ opposite;
            end
            default: begin
                pwm_oe  = 1'b0;
                pwm_out = init_high;
            end
        endcase
    end

    assert_abrupt_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwm_en && abrupt) |=> !pwm_oe);
    assert_stop_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwm_en && !run) |=> !pwm_oe);
    assert_enable_on_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pwm_en |=> pwm_oe);
endmodule

// File: rtl/pwm_timer_channel.sv
module pwm_timer_channel
    import pwm_chan_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [1:0]       rd_addr,
    output logic [CNT_W-1:0] rd_data,
    output logic             pwm_out,
    output logic             pwm_oe
);
    logic [CTL_W-1:0] ctrl;
    logic [CNT_W-1:0] duty_prog;
    logic [CNT_W-1:0] per_prog;
    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] duty_act;
    logic [CNT_W-1:0] per_act;
    logic             wrap;
    logic             opposite;
    logic             cnt_wr;

    assign cnt_wr = wr_en && (wr_addr == ADDR_COUNT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl      <= '0;
            duty_prog <= '0;
            per_prog  <= '0;
        end else if (wr_en) begin
            if (wr_addr == ADDR_CTRL)   ctrl      <= wr_data[CTL_W-1:0];
            if (wr_addr == ADDR_DUTY)   duty_prog <= wr_data;
            if (wr_addr == ADDR_PERIOD) per_prog  <= wr_data;
        end
    end

    always_comb begin
        unique case (rd_addr)
            ADDR_CTRL:   rd_data = {{(CNT_W-CTL_W){1'b0}}, ctrl};
            ADDR_COUNT:  rd_data = count;
            ADDR_DUTY:   rd_data = duty_prog;
            ADDR_PERIOD: rd_data = per_prog;
            default:     rd_data = '0;
        endcase
    end

    pwm_counter #(.CNT_W(CNT_W)) u_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .run       (ctrl[CTL_RUN]),
        .cnt_wr    (cnt_wr),
        .wr_data   (wr_data),
        .duty_prog (duty_prog),
        .per_prog  (per_prog),
        .count     (count),
        .duty_act  (duty_act),
        .per_act   (per_act),
        .wrap      (wrap)
    );

    pwm_compare #(.CNT_W(CNT_W)) u_compare (
        .count    (count),
        .duty_act (duty_act),
        .per_act  (per_act),
        .opposite (opposite)
    );

    pwm_out_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwm_en    (ctrl[CTL_PWM]),
        .abrupt    (ctrl[CTL_ABRUPT]),
        .run       (ctrl[CTL_RUN]),
        .wrap      (wrap),
        .init_high (ctrl[CTL_INIT]),
        .opposite  (opposite),
        .pwm_out   (pwm_out),
        .pwm_oe    (pwm_oe)
    );

    assert_no_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_oe && (duty_act > per_act)) |-> (pwm_out == ctrl[CTL_INIT]));
    assert_off_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwm_oe) |-> (pwm_out == ctrl[CTL_INIT]));
endmodule

// File: tb/pwm_timer_channel_tb.sv
module pwm_timer_channel_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [15:0] wr_data = 16'd0;
    logic [1:0]  rd_addr = 2'd1;
    logic [15:0] rd_data;
    logic        pwm_out;
    logic        pwm_oe;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    pwm_timer_channel u_dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .pwm_out(pwm_out), .pwm_oe(pwm_oe)
    );

    function automatic logic exp_level(input logic [15:0] c, input logic [15:0] d,
                                       input logic [15:0] p, input logic init);
        return init ^ ((c >= d) && (d <= p));
    endfunction

    function automatic logic [15:0] exp_next(input logic [15:0] c, input logic [15:0] p);
        return (c == p) ? 16'd0 : c + 16'd1;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [1:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [15:0] v);
        rd_addr = a; #1; v = rd_data; rd_addr = 2'd1;
    endtask

    task automatic setup(input logic [15:0] d, input logic [15:0] p, input logic [3:0] c);
        tick_en = 1'b0;
        reg_wr(2'd0, 16'd0);
        reg_wr(2'd1, 16'd0);
        reg_wr(2'd2, d);
        reg_wr(2'd3, p);
        @(negedge clk);
        reg_wr(2'd0, {12'd0, c});
        @(negedge clk);
    endtask

    task automatic wait_count(input logic [15:0] v);
        for (int i = 0; i < 300; i++) begin
            if (rd_data == v) break;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [15:0] v;
        logic [15:0] c0;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 oe", {31'd0, pwm_oe}, 32'd0);
        check("R1 out", {31'd0, pwm_out}, 32'd0);
        for (int a = 0; a < 4; a++) begin
            rd_reg(a[1:0], v);
            check("R1 reg", {16'd0, v}, 32'd0);
        end

        // R6 direct write while stopped
        reg_wr(2'd1, 16'h1234);
        check("R6 stopped write", {16'd0, rd_data}, 32'h1234);

        // random runs: R2 R3 R4 R5 R8
        for (int t = 0; t < 10; t++) begin
            logic [15:0] p, d, ec;
            logic init;
            p = 16'($urandom_range(1, 15));
            d = 16'($urandom_range(0, 18));
            init = 1'($urandom_range(0, 1));
            setup(d, p, {1'b0, init, 2'b11});
            ec = 16'd0;
            for (int k = 0; k < 60; k++) begin
                check("R2 R3 count", {16'd0, rd_data}, {16'd0, ec});
                check("R4 R5 level", {31'd0, pwm_out}, {31'd0, exp_level(ec, d, p, init)});
                check("R8 oe on", {31'd0, pwm_oe}, 32'd1);
                tick_en = 1'($urandom_range(0, 1));
                if (tick_en) ec = exp_next(ec, p);
                @(negedge clk);
            end
            tick_en = 1'b0;
        end

        // R5 directed: duty above period
        setup(16'd9, 16'd6, 4'b0111);
        tick_en = 1'b1;
        for (int k = 0; k < 20; k++) begin
            check("R5 held init", {31'd0, pwm_out}, 32'd1);
            @(negedge clk);
        end

        // R6 write wins over counting
        setup(16'd3, 16'd50, 4'b0011);
        tick_en = 1'b1;
        repeat (4) @(negedge clk);
        reg_wr(2'd1, 16'd40);
        check("R6 priority", {16'd0, rd_data}, 32'd40);
        @(negedge clk);
        check("R2 after load", {16'd0, rd_data}, 32'd41);

        // R3 wrap and R7 shadow
        setup(16'd5, 16'd10, 4'b0011);
        tick_en = 1'b1;
        wait_count(16'd10);
        check("R3 at period", {16'd0, rd_data}, 32'd10);
        @(negedge clk);
        check("R3 wrapped", {16'd0, rd_data}, 32'd0);
        wait_count(16'd2);
        tick_en = 1'b0;
        reg_wr(2'd2, 16'd1);
        check("R7 count frozen", {16'd0, rd_data}, 32'd2);
        check("R7 old duty kept", {31'd0, pwm_out}, 32'd0);
        rd_reg(2'd2, v);
        check("R7 readback", {16'd0, v}, 32'd1);
        tick_en = 1'b1;
        @(negedge clk);
        wait_count(16'd0);
        wait_count(16'd1);
        check("R7 new duty live", {31'd0, pwm_out}, 32'd1);

        // R9 abrupt shutdown
        setup(16'd2, 16'd20, 4'b1011);
        tick_en = 1'b1;
        wait_count(16'd5);
        check("R4 opposite", {31'd0, pwm_out}, 32'd1);
        reg_wr(2'd0, 16'b1001);
        @(negedge clk);
        check("R9 abrupt oe", {31'd0, pwm_oe}, 32'd0);
        check("R9 abrupt out", {31'd0, pwm_out}, 32'd0);

        // R9 graceful shutdown
        setup(16'd2, 16'd20, 4'b0111);
        tick_en = 1'b1;
        wait_count(16'd5);
        check("R4 opposite high init", {31'd0, pwm_out}, 32'd0);
        reg_wr(2'd0, 16'b0101);
        @(negedge clk);
        check("R9 drain oe", {31'd0, pwm_oe}, 32'd1);
        check("R9 drain out", {31'd0, pwm_out}, 32'd0);
        wait_count(16'd0);
        check("R9 drained oe", {31'd0, pwm_oe}, 32'd0);
        check("R9 drained out", {31'd0, pwm_out}, 32'd1);

        // R10 stop during drain, R2 hold on stop
        setup(16'd2, 16'd20, 4'b0111);
        tick_en = 1'b1;
        wait_count(16'd5);
        reg_wr(2'd0, 16'b0101);
        reg_wr(2'd0, 16'b0100);
        c0 = rd_data;
        @(negedge clk);
        check("R10 oe", {31'd0, pwm_oe}, 32'd0);
        check("R10 out", {31'd0, pwm_out}, 32'd1);
        check("R2 held on stop", {16'd0, rd_data}, {16'd0, c0});
        tick_en = 1'b0;

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule